// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address presented to a synchronous memory. A base address is captured from the address input whenever a load is requested by either of two strobes. One strobe comes from the processor side and counts only while chip enable is high. The other comes from the controller side and always counts. After a load, the two least significant address bits step through a four-word burst, one step for each clock cycle in which the advance input is high. The upper bits stay fixed for the whole burst.

The stepping order is chosen by a mode input. Linear order adds the step count to the starting low bits, modulo four. Interleaved order XORs the step count into the starting low bits. The block keeps the loaded base and a two-bit step count, and forms the output address from them combinationally. The order input therefore reinterprets the current step at once.

Bursting is optional. A strobe on every cycle loads a fresh random address each cycle without any penalty. The reset input is asserted asynchronously and is released in step with the clock.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_out is 0 and the step count is 0.
- R2: When strobe_ctl is 1 at a clock edge, addr_out equals the addr_in value sampled at that edge from the next cycle on, whatever chip_en is.
- R3: When strobe_cpu is 1 and chip_en is 1 at a clock edge, addr_out equals the sampled addr_in from the next cycle on.
- R4: When strobe_cpu is 1, chip_en is 0 and strobe_ctl is 0, no load happens and addr_out is unchanged.
- R5: A load takes priority over advance in the same cycle: the loaded address appears unchanged, with the step count reset to 0.
- R6: With order_sel = 0 (linear), each advance without a load makes addr_out[1:0] = (start + step) mod 4.
- R7: With order_sel = 1 (interleaved), each advance without a load makes addr_out[1:0] = start XOR step, where step runs 0,1,2,3.
- R8: Advancing never changes addr_out bits above bit 1.
- R9: After four advances the low bits wrap back to the starting value, and the burst continues.
- R10: In a cycle with no load and no advance, addr_out holds its value while order_sel is unchanged.
- R11: Loads on consecutive cycles each present their own address in the following cycle.
- R12: A change of order_sel remaps the current step onto addr_out[1:0] combinationally, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | AW | External base address |
| strobe_cpu | input | 1 | Processor-side load strobe, gated by chip_en |
| strobe_ctl | input | 1 | Controller-side load strobe, always honoured |
| advance | input | 1 | Step the burst by one word |
| chip_en | input | 1 | Enables strobe_cpu |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_out | output | AW | Current word address |

## Verification
Several properties are checked on every cycle: that either strobe loads the sampled address, with the processor strobe gated by chip enable; that the upper bits never move without a load; that idle cycles hold the address; and that a linear advance adds one to the low bits. Interleaved sequences depend on the burst's starting value, which a cycle-local property cannot recall. These sequences, the wrap after four steps, load-over-advance priority and the immediate remap when the order changes are shown only by the bench's directed scenarios.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BURST_BITS = 2;
  typedef logic [BURST_BITS-1:0] burst_idx_t;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_async) begin
          if (!rst_n_async) sync_q[i] <= 1'b0;
          else              sync_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n_async) begin
          if (!rst_n_async) sync_q[i] <= 1'b0;
          else              sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/burst_load_decode.sv
module burst_load_decode (
  input  logic strobe_cpu,
  input  logic strobe_ctl,
  input  logic chip_en,
  output logic load
);
  logic cpu_ok;

  always_comb begin
    cpu_ok = strobe_cpu & chip_en;
    load   = strobe_ctl | cpu_ok;
  end
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       advance,
  output burst_idx_t step
);
  burst_idx_t step_d;
  logic       step_en;

  always_comb begin
    step_en = load | advance;
    if (load) step_d = '0;
    else      step_d = step + burst_idx_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (step_en) step <= step_d;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  burst_idx_t   start_low,
  input  burst_idx_t   step,
  input  burst_order_e order,
  output burst_idx_t   low_out
);
  burst_idx_t lin_low;
  burst_idx_t xor_low;

  always_comb begin
    lin_low = start_low + step;
    xor_low = start_low ^ step;
    unique case (order)
      ORD_LINEAR: low_out = lin_low;
      ORD_XOR:    low_out = xor_low;
      default:    low_out = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strobe_cpu,
  input  logic          strobe_ctl,
  input  logic          advance,
  input  logic          chip_en,
  input  logic          order_sel,
  output logic [AW-1:0] addr_out
);
  localparam int HI_W = AW - BURST_BITS;

  logic          rst_sync_n;
  logic          load;
  burst_idx_t    step;
  burst_idx_t    low_out;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_d;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_sync_n)
  );

  burst_load_decode u_dec (
    .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl),
    .chip_en   (chip_en),
    .load      (load)
  );

  burst_step_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load),
    .advance(advance),
    .step   (step)
  );

  always_comb base_d = addr_in;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) base_q <= '0;
    else if (load)   base_q <= base_d;
  end

  burst_order_map u_map (
    .start_low(base_q[BURST_BITS-1:0]),
    .step     (step),
    .order    (burst_order_e'(order_sel)),
    .low_out  (low_out)
  );

  always_comb addr_out = {base_q[AW-1 -: HI_W], low_out};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [AW-1:0] addr_in,
  input logic          strobe_cpu,
  input logic          strobe_ctl,
  input logic          advance,
  input logic          chip_en,
  input logic          order_sel,
  input logic [AW-1:0] addr_out
);
  // R2 / R3: either qualified strobe captures the address
  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strobe_ctl |=> addr_out == $past(addr_in));

  a_r3_cpu_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_cpu && chip_en) |=> addr_out == $past(addr_in));

  // R4: gated processor strobe alone leaves the address as it was
  a_r4_cpu_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_cpu && !chip_en && !strobe_ctl && !advance)
      |=> ($stable(order_sel) -> $stable(addr_out)));

  // R8: upper bits move only on a load
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_ctl && !(strobe_cpu && chip_en))
      |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));

  // R10: idle cycle holds the address
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_ctl && !(strobe_cpu && chip_en) && !advance)
      |=> ($stable(order_sel) -> $stable(addr_out)));

  // R6: linear advance adds one to the low bits
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_ctl && !(strobe_cpu && chip_en) && advance && !order_sel)
      |=> (!order_sel -> addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .addr_in   (addr_in),
  .strobe_cpu(strobe_cpu),
  .strobe_ctl(strobe_ctl),
  .advance   (advance),
  .chip_en   (chip_en),
  .order_sel (order_sel),
  .addr_out  (addr_out)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strobe_cpu;
  logic          strobe_ctl;
  logic          advance;
  logic          chip_en;
  logic          order_sel;
  logic [AW-1:0] addr_out;

  int total = 0;
  int bad   = 0;

  burst_addr_seq #(.AW(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl),
    .advance   (advance),
    .chip_en   (chip_en),
    .order_sel (order_sel),
    .addr_out  (addr_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 2 ns after the rising edge
  task automatic cyc(input logic [AW-1:0] a, input logic sc, input logic sp,
                     input logic ce, input logic adv);
    @(negedge clk);
    addr_in = a; strobe_ctl = sc; strobe_cpu = sp; chip_en = ce; advance = adv;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k, input logic m);
    return m ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic t_reset();
    chk("R1 reset", addr_out, '0);
  endtask

  task automatic t_ctl_load();
    cyc(16'hA5C6, 1, 0, 0, 0);
    chk("R2 ctl load with chip_en low", addr_out, 16'hA5C6);
  endtask

  task automatic t_cpu_load();
    cyc(16'h1237, 0, 1, 1, 0);
    chk("R3 cpu load", addr_out, 16'h1237);
  endtask

  task automatic t_cpu_ignored();
    cyc(16'hFFFF, 0, 1, 0, 0);
    chk("R4 cpu strobe ignored", addr_out, 16'h1237);
    cyc(16'h0000, 0, 0, 0, 0);
    chk("R4 still unchanged", addr_out, 16'h1237);
  endtask

  task automatic t_burst(input logic m, input logic [AW-1:0] base, input string rq);
    order_sel = m;
    cyc(base, 1, 0, 0, 0);
    chk(rq, addr_out, base);
    for (int k = 1; k <= 6; k++) begin
      cyc(16'h0000, 0, 0, 0, 1);
      chk(rq, addr_out, {base[AW-1:2], exp_low(base[1:0], 2'(k), m)});
      chk("R8 upper bits fixed", {2'b00, addr_out[AW-1:2]}, {2'b00, base[AW-1:2]});
      if (k == 4) chk("R9 wrap to start", addr_out, base);
    end
  endtask

  task automatic t_hold();
    order_sel = 1'b0;
    cyc(16'h3330, 1, 0, 0, 0);
    cyc(16'h0000, 0, 0, 0, 1);
    cyc(16'hBEEF, 0, 0, 1, 0);
    chk("R10 hold", addr_out, 16'h3331);
    cyc(16'hBEEF, 0, 0, 0, 0);
    chk("R10 hold again", addr_out, 16'h3331);
  endtask

  task automatic t_priority();
    order_sel = 1'b0;
    cyc(16'h5552, 0, 0, 0, 1);
    cyc(16'h7772, 1, 0, 0, 1);
    chk("R5 load over advance", addr_out, 16'h7772);
    cyc(16'h0000, 0, 0, 0, 1);
    chk("R5 step restarted", addr_out, 16'h7773);
    cyc(16'h9990, 0, 1, 1, 1);
    chk("R5 cpu load over advance", addr_out, 16'h9990);
  endtask

  task automatic t_back_to_back();
    order_sel = 1'b1;
    cyc(16'h0101, 1, 0, 0, 1);
    chk("R11 first", addr_out, 16'h0101);
    cyc(16'h2022, 0, 1, 1, 1);
    chk("R11 second", addr_out, 16'h2022);
    cyc(16'h3033, 1, 1, 1, 0);
    chk("R11 third", addr_out, 16'h3033);
  endtask

  task automatic t_mode_switch();
    order_sel = 1'b0;
    cyc(16'h0001, 1, 0, 0, 0);
    cyc(16'h0000, 0, 0, 0, 1);
    chk("R12 linear view", addr_out, 16'h0002);
    @(negedge clk);
    order_sel = 1'b1;
    #1;
    chk("R12 interleaved view", addr_out, 16'h0000);
    order_sel = 1'b0;
    #1;
    chk("R12 back to linear", addr_out, 16'h0002);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_in = '0; strobe_cpu = 0; strobe_ctl = 0;
    advance = 0; chip_en = 0; order_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_ctl_load();
    t_cpu_load();
    t_cpu_ignored();
    t_burst(1'b0, 16'h4441, "R6 linear order");
    t_burst(1'b1, 16'h8882, "R7 interleaved order");
    t_hold();
    t_priority();
    t_back_to_back();
    t_mode_switch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule